// File: doc/BRIEF.md
# FIFO Threshold Interrupt Generator

This block watches the fill state of four packet FIFOs: the transmit data FIFO, the transmit status FIFO, the receive data FIFO and the receive status FIFO. It raises a sticky interrupt flag for each one when that FIFO crosses a level that software has programmed. All four levels are held in one 32-bit threshold register. Data FIFO levels count 64-byte blocks. Status FIFO levels count DWORDs. The receive data condition fires when free space falls below its level. The other three conditions fire when their measure rises above their level.

The FIFOs report raw occupancy. Data FIFOs report free bytes, and the block drops the low six bits to turn bytes into blocks. Status FIFOs report used DWORDs. Software reads the flags and clears them through a write-one-to-clear register. A per-flag enable mask selects which flags drive the single combined interrupt line. All registers sit on a simple register bus. Writes take effect on the clock edge. Read data is combinational from the address.

Top module: `fifo_thr_irq`

## Requirements
- R1: After reset, the threshold register (offset 0x068) reads 0x4800_0000, the flag register (offset 0x058) reads 0, the enable register (offset 0x05C) reads 0, and the interrupt line is low.
- R2: A write to offset 0x068 updates only the bytes whose strobe bit is set: strobe bit k covers write data bits 8k+7:8k. The fields are TX data level 31:24, TX status level 23:16, RX data level 15:8 and RX status level 7:0.
- R3: Flag bit 3 sets on the edge after a cycle in which floor(TX data free bytes / 64) is strictly greater than bits 31:24.
- R4: Flag bit 2 sets on the edge after a cycle in which the TX status used count is strictly greater than bits 23:16.
- R5: Flag bit 1 sets on the edge after a cycle in which floor(RX data free bytes / 64) is strictly less than bits 15:8.
- R6: Flag bit 0 sets on the edge after a cycle in which the RX status used count is strictly greater than bits 7:0.
- R7: A set flag stays set after its condition goes away, and a clear flag stays clear while its condition is false.
- R8: A write to offset 0x058 with strobe bit 0 set clears each flag whose write data bit (bits 3:0) is 1. Zero bits have no effect. If the condition still holds, the flag reads 0 in the cycle after the clear and sets again on the following edge.
- R9: The interrupt line is high exactly when some flag bit is set and its enable bit is set. The enable bits are written at offset 0x05C, bits 3:0, under strobe bit 0.
- R10: A write to any other offset changes no register. A read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Write enable |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Byte strobes for the write |
| reg_rdata | output | 32 | Read data for reg_addr |
| txd_free_bytes | input | DCNT_W | TX data FIFO free space, bytes |
| txs_used | input | SCNT_W | TX status FIFO used entries, DWORDs |
| rxd_free_bytes | input | DCNT_W | RX data FIFO free space, bytes |
| rxs_used | input | SCNT_W | RX status FIFO used entries, DWORDs |
| irq_flags | output | 4 | Sticky flags: 3 TX data, 2 TX status, 1 RX data, 0 RX status |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The bench builds the block with DCNT_W=16 and SCNT_W=10, which are wider than the defaults. Data FIFOs then report up to 1023 blocks and status FIFOs up to 1023 DWORDs, so a count can exceed the largest 8-bit level. This reaches the widened comparison path, where a level of 0xFF must still be beaten by a larger count. The 64-byte boundary is probed on both sides: 1087 against 1088 bytes, and 511 against 512 bytes. A clear that lands while its condition persists is also checked.

// File: rtl/fthr_pkg.sv
package fthr_pkg;
  localparam int REG_W   = 32;
  localparam int LVL_W   = 8;
  localparam int NUM_SRC = 4;
  localparam int BLK_SHIFT = 6;

  // flag / field index; field i lives at bits 8*i+7:8*i
  localparam int IX_RXS = 0;
  localparam int IX_RXD = 1;
  localparam int IX_TXS = 2;
  localparam int IX_TXD = 3;

  localparam logic [11:0] OFS_THR = 12'h068;
  localparam logic [11:0] OFS_STS = 12'h058;
  localparam logic [11:0] OFS_EN  = 12'h05C;

  localparam logic [REG_W-1:0] THR_RST = 32'h4800_0000;

  function automatic logic [REG_W-1:0] merge_bytes(
    input logic [REG_W-1:0] old_v,
    input logic [REG_W-1:0] new_v,
    input logic [REG_W/8-1:0] be
  );
    logic [REG_W-1:0] r;
    r = old_v;
    for (int k = 0; k < REG_W/8; k++)
      if (be[k]) r[8*k +: 8] = new_v[8*k +: 8];
    return r;
  endfunction

  function automatic bool_t_dummy(input logic a);
    return a;
  endfunction
endpackage

// File: rtl/fthr_regfile.sv
module fthr_regfile
  import fthr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_wr,
  input  logic [REG_W-1:0]     reg_wdata,
  input  logic [REG_W/8-1:0]   reg_be,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic [NUM_SRC-1:0]   flags,
  output logic [REG_W-1:0]     thr_q,
  output logic [NUM_SRC-1:0]   en_q,
  output logic [NUM_SRC-1:0]   clr_hit
);
  localparam logic [ADDR_W-1:0] A_THR = ADDR_W'(OFS_THR);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STS);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFS_EN);

  logic wr_thr, wr_sts, wr_en;
  assign wr_thr = reg_wr && (reg_addr == A_THR);
  assign wr_sts = reg_wr && (reg_addr == A_STS) && reg_be[0];
  assign wr_en  = reg_wr && (reg_addr == A_EN)  && reg_be[0];

  assign clr_hit = wr_sts ? reg_wdata[NUM_SRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= THR_RST;
      en_q  <= '0;
    end else begin
      if (wr_thr) thr_q <= merge_bytes(thr_q, reg_wdata, reg_be);
      if (wr_en)  en_q  <= reg_wdata[NUM_SRC-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_THR)      reg_rdata = thr_q;
    else if (reg_addr == A_STS) reg_rdata[NUM_SRC-1:0] = flags;
    else if (reg_addr == A_EN)  reg_rdata[NUM_SRC-1:0] = en_q;
  end

  // R2: a full-strobe write lands unchanged
  p_full_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_thr && (reg_be == '1) |=> thr_q == $past(reg_wdata));
  // R2: an unstrobed top byte is kept
  p_top_byte_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_thr && !reg_be[3] |=> thr_q[31:24] == $past(thr_q[31:24]));
  // R10: no threshold write, no change
  p_thr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_thr |=> $stable(thr_q));
endmodule

// File: rtl/fthr_level_cmp.sv
module fthr_level_cmp
  import fthr_pkg::*;
#(
  parameter int CNT_W = 14,
  parameter int SHIFT = 6,
  parameter bit ABOVE = 1'b1
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [LVL_W-1:0] lvl,
  output logic             hit
);
  localparam int UNIT_W = CNT_W - SHIFT;
  localparam int CMP_W  = (UNIT_W > LVL_W) ? UNIT_W : LVL_W;

  function automatic logic [CMP_W-1:0] to_units(input logic [CNT_W-1:0] c);
    return CMP_W'(c >> SHIFT);
  endfunction

  function automatic logic [CMP_W-1:0] widen(input logic [LVL_W-1:0] l);
    return CMP_W'(l);
  endfunction

  logic [CMP_W-1:0] units, level;
  assign units = to_units(cnt);
  assign level = widen(lvl);

  generate
    if (ABOVE) begin : g_above
      assign hit = units > level;
    end else begin : g_below
      assign hit = units < level;
    end
  endgenerate
endmodule

// File: rtl/fthr_flags.sv
module fthr_flags
  import fthr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] cond,
  input  logic [NUM_SRC-1:0] clr_hit,
  input  logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] flags,
  output logic               irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags | cond) & ~clr_hit;
  end

  assign irq_o = |(flags & en_q);

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
      // R3 R4 R5 R6: a held condition sets the flag next edge
      p_cond_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cond[i] && !clr_hit[i] |=> flags[i]);
      p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flags[i] && !clr_hit[i] |=> flags[i]);
      p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !flags[i] && !cond[i] |=> !flags[i]);
      p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit[i] |=> !flags[i]);
    end
  endgenerate

  p_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq_o);
endmodule

// File: rtl/fifo_thr_irq.sv
module fifo_thr_irq
  import fthr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DCNT_W = 14,
  parameter int SCNT_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  input  logic [3:0]        reg_be,
  output logic [31:0]       reg_rdata,
  input  logic [DCNT_W-1:0] txd_free_bytes,
  input  logic [SCNT_W-1:0] txs_used,
  input  logic [DCNT_W-1:0] rxd_free_bytes,
  input  logic [SCNT_W-1:0] rxs_used,
  output logic [3:0]        irq_flags,
  output logic              irq_o
);
  localparam int MAX_W = (DCNT_W > SCNT_W) ? DCNT_W : SCNT_W;

  logic [REG_W-1:0]   thr_q;
  logic [NUM_SRC-1:0] en_q, clr_hit, cond;
  logic [MAX_W-1:0]   cnt_ext [NUM_SRC];

  assign cnt_ext[IX_RXS] = MAX_W'(rxs_used);
  assign cnt_ext[IX_RXD] = MAX_W'(rxd_free_bytes);
  assign cnt_ext[IX_TXS] = MAX_W'(txs_used);
  assign cnt_ext[IX_TXD] = MAX_W'(txd_free_bytes);

  fthr_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rdata(reg_rdata),
    .flags(irq_flags), .thr_q(thr_q), .en_q(en_q), .clr_hit(clr_hit)
  );

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      localparam bit IS_DATA = (i == IX_RXD) || (i == IX_TXD);
      fthr_level_cmp #(
        .CNT_W(MAX_W),
        .SHIFT(IS_DATA ? BLK_SHIFT : 0),
        .ABOVE(i != IX_RXD)
      ) u_cmp (
        .cnt(cnt_ext[i]),
        .lvl(thr_q[LVL_W*i +: LVL_W]),
        .hit(cond[i])
      );
    end
  endgenerate

  fthr_flags u_flags (
    .clk(clk), .rst_n(rst_n), .cond(cond), .clr_hit(clr_hit),
    .en_q(en_q), .flags(irq_flags), .irq_o(irq_o)
  );
endmodule

// File: tb/fifo_thr_irq_tb_top.sv
module fifo_thr_irq_tb_top;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int SW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [3:0] reg_be = '0;
  logic [31:0] reg_rdata;
  logic [DW-1:0] txd_free_bytes = '0;
  logic [SW-1:0] txs_used = '0;
  logic [DW-1:0] rxd_free_bytes = 16'd4096;
  logic [SW-1:0] rxs_used = '0;
  logic [3:0] irq_flags;
  logic irq_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fifo_thr_irq #(.ADDR_W(AW), .DCNT_W(DW), .SCNT_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rdata(reg_rdata),
    .txd_free_bytes(txd_free_bytes), .txs_used(txs_used),
    .rxd_free_bytes(rxd_free_bytes), .rxs_used(rxs_used),
    .irq_flags(irq_flags), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // behavioural reference model
  int m_thr;
  int m_en;
  bit m_fl [4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_thr = 32'h4800_0000;
      m_en = 0;
      foreach (m_fl[i]) m_fl[i] = 0;
    end else begin
      bit c [4];
      int clr;
      c[3] = (int'(txd_free_bytes) / 64) > ((m_thr >> 24) & 255);
      c[2] = int'(txs_used) > ((m_thr >> 16) & 255);
      c[1] = (int'(rxd_free_bytes) / 64) < ((m_thr >> 8) & 255);
      c[0] = int'(rxs_used) > (m_thr & 255);
      clr = (reg_wr && reg_addr == 12'h058 && reg_be[0]) ? int'(reg_wdata[3:0]) : 0;
      for (int i = 0; i < 4; i++)
        if ((clr >> i) & 1) m_fl[i] = 0;
        else if (c[i]) m_fl[i] = 1;
      if (reg_wr && reg_addr == 12'h068)
        for (int k = 0; k < 4; k++)
          if (reg_be[k]) m_thr = (m_thr & ~(255 << (8*k))) | (int'(reg_wdata[8*k +: 8]) << (8*k));
      if (reg_wr && reg_addr == 12'h05C && reg_be[0]) m_en = int'(reg_wdata[3:0]);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] mf;
      for (int i = 0; i < 4; i++) mf[i] = m_fl[i];
      chk("R7 model flags", {28'd0, irq_flags}, {28'd0, mf});
      chk("R9 model irq", {31'd0, irq_o}, {31'd0, |(mf & m_en[3:0])});
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_be = be; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    rd(12'h068, v); chk("R1 thr reset", v, 32'h4800_0000);
    rd(12'h058, v); chk("R1 flags reset", v, 32'h0);
    rd(12'h05C, v); chk("R1 en reset", v, 32'h0);
    chk("R1 irq reset", {31'd0, irq_o}, 32'h0);

    wr(12'h068, 32'h1122_3344, 4'b0101);
    rd(12'h068, v); chk("R2 strobed bytes", v, 32'h4822_0044);

    wr(12'h068, 32'h1005_0803, 4'hF);
    rd(12'h068, v); chk("R2 full write", v, 32'h1005_0803);

    txd_free_bytes = 16'd1087; tick(1); chk("R3 at level", {31'd0, irq_flags[3]}, 0);
    txd_free_bytes = 16'd1088; tick(1); chk("R3 above level", {31'd0, irq_flags[3]}, 1);
    txd_free_bytes = 16'd0; tick(2); chk("R7 sticky txd", {31'd0, irq_flags[3]}, 1);

    txs_used = 10'd5; tick(1); chk("R4 at level", {31'd0, irq_flags[2]}, 0);
    txs_used = 10'd6; tick(1); chk("R4 above level", {31'd0, irq_flags[2]}, 1);
    txs_used = 10'd0;

    rxd_free_bytes = 16'd512; tick(1); chk("R5 at level", {31'd0, irq_flags[1]}, 0);
    rxd_free_bytes = 16'd511; tick(1); chk("R5 below level", {31'd0, irq_flags[1]}, 1);
    rxd_free_bytes = 16'd4096;

    rxs_used = 10'd3; tick(1); chk("R6 at level", {31'd0, irq_flags[0]}, 0);
    rxs_used = 10'd4; tick(1); chk("R6 above level", {31'd0, irq_flags[0]}, 1);
    rxs_used = 10'd0; tick(1);

    rd(12'h058, v); chk("R7 all held", v, 32'hF);
    chk("R9 masked", {31'd0, irq_o}, 0);
    wr(12'h05C, 32'h4, 4'h1);
    chk("R9 enabled", {31'd0, irq_o}, 1);
    wr(12'h058, 32'h4, 4'h1);
    chk("R8 clear bit2", {28'd0, irq_flags}, 32'hB);
    chk("R9 after clear", {31'd0, irq_o}, 0);
    wr(12'h058, 32'h0, 4'h1);
    chk("R8 zero bits", {28'd0, irq_flags}, 32'hB);

    rxs_used = 10'd10;
    @(negedge clk);
    reg_addr = 12'h058; reg_wdata = 32'h1; reg_be = 4'h1; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = '0;
    chk("R8 cleared cycle", {31'd0, irq_flags[0]}, 0);
    tick(1);
    chk("R8 sets again", {31'd0, irq_flags[0]}, 1);
    rxs_used = 10'd0; tick(1);
    wr(12'h058, 32'hF, 4'h1);
    chk("R8 clear all", {28'd0, irq_flags}, 0);

    wr(12'h070, 32'hFFFF_FFFF, 4'hF);
    rd(12'h068, v); chk("R10 thr kept", v, 32'h1005_0803);
    rd(12'h05C, v); chk("R10 en kept", v, 32'h4);
    rd(12'h070, v); chk("R10 unmapped read", v, 32'h0);

    wr(12'h068, 32'hFFFF_FFFF, 4'hF);
    txd_free_bytes = 16'hFFFF; txs_used = 10'd1023;
    tick(2);
    chk("R3 R4 R5 wide counts", {28'd0, irq_flags}, 32'hE);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule